// File: doc/BRIEF.md
# Programmable External Bus Cycle Sequencer

This block runs read and write cycles on an external 16-bit memory bus for a small processor core. A request carries an address, a read/write flag, two byte enables and write data. The block turns it into a timed pin sequence. An address-latch strobe comes first. An optional delay state follows, then a read strobe or high/low write strobes that are held for a programmed number of wait states. An optional turnaround state ends the cycle. A one-cycle response then returns the captured read data.

Five chip-select lines decode the upper address bits against a base and mask per line. Each line works in one of four modes. An address-mode line stays low for the whole cycle. The read, write and read/write modes pull the line low only while the matching strobe is active. The number of address lines driven can be cut down to cover 256 KB, 1 MB or 8 MB. An external master can take the bus through a hold request and grant pair. The grant is given only between cycles.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is active, every `cs_n` is 1 and every `cs_oe` is 1. After reset, `cs_oe` equals `{cs_en[4:1],1}`: line 0 is always driven, and lines not enabled float.
- R2: An accepted request (`req_valid` and `req_ready` at a clock edge) makes `ale` high for the next cycle. When `cfg_ale_long`=1 it stays high for one more cycle. No strobe is active while `ale` is high.
- R3: The access phase lasts 1+`cfg_waits` cycles, with `cfg_waits` from 0 to 15. In a read cycle (`req_we`=0), `rd_n` is low for exactly that phase.
- R4: A cycle is a write only when `req_we`=1 and at least one byte enable is set. In the access phase, `wrh_n` is low if `req_be[1]`=1 and `wrl_n` is low if `req_be[0]`=1, while `data_oe`=1 and `data_out` carries the write data. With `req_we`=1 and `req_be`=0, no strobe and no `data_oe` occurs.
- R5: With `cfg_rw_delay`=1, one cycle with no strobe is placed between the last `ale` cycle and the access phase.
- R6: With `cfg_tri_wait`=1, one cycle with no strobe and no data drive follows the access phase, before `req_ready` returns.
- R7: The 2-bit mode field for line i is `cs_mode[2i+1:2i]`: 0 = address, 1 = read, 2 = write, 3 = read/write. An address-mode line is low from the first `ale` cycle to the end of the cycle. A read-mode line is low only during the access phase of read cycles. A write-mode line is low only during the access phase of write cycles (per R4). A read/write-mode line is low during the access phase of both.
- R8: Line i matches when `((addr[22:16] ^ base_i) & mask_i)==0`, where `base_i`/`mask_i` are bits `[7i+6:7i]` of `cs_base`/`cs_mask`. Line i also needs `cs_en[i]`=1, except line 0, which always takes part. The lowest-numbered matching line is selected. With no match, the cycle runs with every `cs_n` high.
- R9: During a cycle, `bus_addr` carries the request address with its upper bits forced to 0. `cfg_seg` 0 keeps bits 17:0, 1 keeps bits 19:0, and 2 or 3 keep bits 22:0.
- R10: When `hold_n` is low in an idle cycle, from the next cycle `hlda_n` is low, `req_ready` is low, and all strobes, `ale`, `data_oe` and `cs_n` are inactive. This continues until a cycle after `hold_n` rises. A hold request pending together with a bus request wins.
- R11: `rsp_valid` is high for one cycle, the cycle after the last access cycle. For reads, `rsp_rdata` holds `data_in` as sampled at the end of that last access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 23 | Byte address |
| req_we | input | 1 | 1 = write request |
| req_be | input | 2 | Byte enables (1 = high byte, 0 = low byte) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Cycle completed |
| rsp_rdata | output | 16 | Captured read data |
| cfg_ale_long | input | 1 | Two-cycle address latch strobe |
| cfg_waits | input | 4 | Extra access wait states |
| cfg_tri_wait | input | 1 | Add turnaround state |
| cfg_rw_delay | input | 1 | Delay strobes by one state |
| cfg_seg | input | 2 | Address span select |
| cs_en | input | 5 | Chip-select line enables |
| cs_mode | input | 10 | Mode per line |
| cs_base | input | 35 | Match base per line |
| cs_mask | input | 35 | Match mask per line |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, active low |
| bus_addr | output | 23 | External address lines |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | 16 | Data bus output value |
| data_in | input | 16 | Data bus input value |
| cs_n | output | 5 | Chip-select levels, active low |
| cs_oe | output | 5 | Chip-select drive enables |
| hold_n | input | 1 | Bus hold request, active low |
| hlda_n | output | 1 | Bus hold grant, active low |

## Verification
The hardest case to reach is a hold request that arrives in the middle of a cycle while another bus request is already waiting. The grant must wait for the running cycle to end, and then it must win over the waiting request. The stimulus starts a cycle and lowers `hold_n` during its access phase. It raises `req_valid` with a second request at the same time and releases hold many cycles later. The reference model then expects the grant right after the first cycle and the second cycle only after the release. Strobe-gated chip selects are exercised by sending reads and writes with all byte-enable patterns to lines in each mode.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int NCS   = 5,
  parameter int AW    = 23,
  parameter int DW    = 16,
  parameter int WW    = 4,
  parameter int TAGLO = 16,
  parameter int SEG_A = 18,
  parameter int SEG_B = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [AW-1:0]               req_addr,
  input  logic                        req_we,
  input  logic [1:0]                  req_be,
  input  logic [DW-1:0]               req_wdata,
  output logic                        rsp_valid,
  output logic [DW-1:0]               rsp_rdata,
  input  logic                        cfg_ale_long,
  input  logic [WW-1:0]               cfg_waits,
  input  logic                        cfg_tri_wait,
  input  logic                        cfg_rw_delay,
  input  logic [1:0]                  cfg_seg,
  input  logic [NCS-1:0]              cs_en,
  input  logic [2*NCS-1:0]            cs_mode,
  input  logic [NCS*(AW-TAGLO)-1:0]   cs_base,
  input  logic [NCS*(AW-TAGLO)-1:0]   cs_mask,
  output logic                        ale,
  output logic                        rd_n,
  output logic                        wrh_n,
  output logic                        wrl_n,
  output logic [AW-1:0]               bus_addr,
  output logic                        data_oe,
  output logic [DW-1:0]               data_out,
  input  logic [DW-1:0]               data_in,
  output logic [NCS-1:0]              cs_n,
  output logic [NCS-1:0]              cs_oe,
  input  logic                        hold_n,
  output logic                        hlda_n
);
  localparam int TW = AW - TAGLO;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_ADDR, S_ALE2, S_DLY, S_ACC, S_TRI} st_t;

  st_t            st;
  logic [AW-1:0]  addr_q;
  logic           we_q;
  logic [1:0]     be_q;
  logic [DW-1:0]  wd_q;
  logic [NCS-1:0] sel_q, hit, sel_d;
  logic [WW-1:0]  cnt;
  logic           run;
  logic [AW-1:0]  seg_mask;
  logic           in_cyc, acc, rd_cyc, wr_cyc;

  assign in_cyc = (st == S_ADDR) || (st == S_ALE2) || (st == S_DLY) || (st == S_ACC) || (st == S_TRI);
  assign acc    = (st == S_ACC);
  assign rd_cyc = !we_q;
  assign wr_cyc = we_q && (|be_q);

  assign req_ready = (st == S_IDLE) && hold_n;
  assign hlda_n    = (st != S_HOLD);
  assign ale       = (st == S_ADDR) || (st == S_ALE2);
  assign rd_n      = !(acc && rd_cyc);
  assign wrh_n     = !(acc && we_q && be_q[1]);
  assign wrl_n     = !(acc && we_q && be_q[0]);
  assign data_oe   = acc && wr_cyc;
  assign data_out  = wd_q;
  assign bus_addr  = addr_q & seg_mask;
  assign cs_oe     = run ? {cs_en[NCS-1:1], 1'b1} : {NCS{1'b1}};

  always_comb begin
    case (cfg_seg)
      2'd0:    seg_mask = {AW{1'b1}} >> (AW - SEG_A);
      2'd1:    seg_mask = {AW{1'b1}} >> (AW - SEG_B);
      default: seg_mask = {AW{1'b1}};
    endcase
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    logic [TW-1:0] base_g, mask_g;
    logic [1:0]    mode_g;
    logic          strobe_ok;
    assign base_g    = cs_base[g*TW +: TW];
    assign mask_g    = cs_mask[g*TW +: TW];
    assign mode_g    = cs_mode[2*g +: 2];
    assign hit[g]    = (g == 0 || cs_en[g]) && (((req_addr[AW-1:TAGLO] ^ base_g) & mask_g) == '0);
    assign strobe_ok = acc && ((mode_g[0] && rd_cyc) || (mode_g[1] && wr_cyc));
    assign cs_n[g]   = !(sel_q[g] && ((mode_g == 2'd0) ? in_cyc : strobe_ok));
  end

  always_comb begin
    sel_d = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if (hit[i]) sel_d = NCS'(1) << i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      we_q      <= 1'b0;
      be_q      <= '0;
      wd_q      <= '0;
      sel_q     <= '0;
      cnt       <= '0;
      run       <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      run       <= 1'b1;
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (!hold_n) st <= S_HOLD;
          else if (req_valid) begin
            st     <= S_ADDR;
            addr_q <= req_addr;
            we_q   <= req_we;
            be_q   <= req_be;
            wd_q   <= req_wdata;
            sel_q  <= sel_d;
            cnt    <= cfg_waits;
          end
        S_HOLD: if (hold_n) st <= S_IDLE;
        S_ADDR: st <= cfg_ale_long ? S_ALE2 : (cfg_rw_delay ? S_DLY : S_ACC);
        S_ALE2: st <= cfg_rw_delay ? S_DLY : S_ACC;
        S_DLY:  st <= S_ACC;
        S_ACC:
          if (cnt == '0) begin
            st        <= cfg_tri_wait ? S_TRI : S_IDLE;
            rsp_valid <= 1'b1;
            if (rd_cyc) rsp_rdata <= data_in;
          end else cnt <= cnt - 1'b1;
        S_TRI:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int NCS = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ale,
  input logic           rd_n,
  input logic           wrh_n,
  input logic           wrl_n,
  input logic           data_oe,
  input logic           rsp_valid,
  input logic [NCS-1:0] cs_n,
  input logic [NCS-1:0] cs_oe,
  input logic           hlda_n
);
  always @(posedge clk)
    if (!rst_n) p_reset_cs_high_r1: assert ((&cs_n) && (&cs_oe));

  p_ale_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wrh_n && wrl_n));

  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wrh_n && wrl_n));

  p_doe_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!wrh_n || !wrl_n));

  p_single_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hlda_n |-> ((&cs_n) && rd_n && wrh_n && wrl_n && !data_oe && !ale));

  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wrh_n(wrh_n), .wrl_n(wrl_n),
  .data_oe(data_oe), .rsp_valid(rsp_valid), .cs_n(cs_n), .cs_oe(cs_oe), .hlda_n(hlda_n)
);

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_we = 0;
  logic [22:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0, data_in = '0;
  logic        cfg_ale_long = 0, cfg_tri_wait = 0, cfg_rw_delay = 0;
  logic [3:0]  cfg_waits = 0;
  logic [1:0]  cfg_seg = 2;
  logic [4:0]  cs_en = 5'b11111;
  logic [9:0]  cs_mode;
  logic [34:0] cs_base, cs_mask;
  logic        hold_n = 1;
  logic        req_ready, rsp_valid, ale, rd_n, wrh_n, wrl_n, data_oe, hlda_n;
  logic [15:0] rsp_rdata, data_out;
  logic [22:0] bus_addr;
  logic [4:0]  cs_n, cs_oe;

  ext_bus_seq i_ext_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_ale_long(cfg_ale_long),
    .cfg_waits(cfg_waits), .cfg_tri_wait(cfg_tri_wait), .cfg_rw_delay(cfg_rw_delay),
    .cfg_seg(cfg_seg), .cs_en(cs_en), .cs_mode(cs_mode), .cs_base(cs_base),
    .cs_mask(cs_mask), .ale(ale), .rd_n(rd_n), .wrh_n(wrh_n), .wrl_n(wrl_n),
    .bus_addr(bus_addr), .data_oe(data_oe), .data_out(data_out), .data_in(data_in),
    .cs_n(cs_n), .cs_oe(cs_oe), .hold_n(hold_n), .hlda_n(hlda_n));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
    end
  endtask

  // reference model: one vector per cycle
  typedef struct packed {
    logic idle, hold, ale, rd_n, wrh_n, wrl_n, doe, rsp;
    logic [4:0] csn;
  } vec_t;

  vec_t        q[$];
  vec_t        cur;
  bit          held = 0;
  int          n_acc = 0;
  logic [22:0] m_addr;
  logic [15:0] m_wdata, m_rdata;
  logic        m_we;

  function automatic vec_t idle_v();
    vec_t v = '{idle:1, hold:0, ale:0, rd_n:1, wrh_n:1, wrl_n:1, doe:0, rsp:0, csn:5'h1f};
    return v;
  endfunction

  function automatic int pick_line(input logic [22:0] a);
    for (int i = 0; i < 5; i++) begin
      logic [6:0] b = cs_base[7*i +: 7];
      logic [6:0] m = cs_mask[7*i +: 7];
      if ((i == 0 || cs_en[i]) && (((a[22:16] ^ b) & m) == 0)) return i;
    end
    return -1;
  endfunction

  task automatic build(input logic [22:0] a, input logic we, input logic [1:0] be);
    int   ln   = pick_line(a);
    bit   isw  = we && (be != 0);
    bit   isr  = !we;
    int   md   = (ln >= 0) ? int'(cs_mode[2*ln +: 2]) : 0;
    int   nale = cfg_ale_long ? 2 : 1;
    vec_t v;
    for (int k = 0; k < nale; k++) begin
      v = idle_v(); v.idle = 0; v.ale = 1;
      if (ln >= 0 && md == 0) v.csn[ln] = 0;
      q.push_back(v);
    end
    if (cfg_rw_delay) begin
      v = idle_v(); v.idle = 0;
      if (ln >= 0 && md == 0) v.csn[ln] = 0;
      q.push_back(v);
    end
    for (int k = 0; k <= int'(cfg_waits); k++) begin
      v = idle_v(); v.idle = 0;
      v.rd_n = !isr; v.wrh_n = !(we && be[1]); v.wrl_n = !(we && be[0]); v.doe = isw;
      if (ln >= 0 && (md == 0 || (md[0] && isr) || (md[1] && isw))) v.csn[ln] = 0;
      q.push_back(v);
    end
    if (cfg_tri_wait) begin
      v = idle_v(); v.idle = 0; v.rsp = 1;
      if (ln >= 0 && md == 0) v.csn[ln] = 0;
      q.push_back(v);
      q.push_back(idle_v());
    end else begin
      v = idle_v(); v.rsp = 1;
      q.push_back(v);
    end
  endtask

  function automatic logic [22:0] seg_keep();
    return (cfg_seg == 0) ? 23'h3ffff : (cfg_seg == 1) ? 23'hfffff : 23'h7fffff;
  endfunction

  initial cur = '0;

  always begin
    @(posedge clk);
    if (rst_n) begin
      if (q.size() > 0) cur = q.pop_front();
      else if (held) begin
        if (hold_n) begin held = 0; cur = idle_v(); end
      end else if (!hold_n) begin
        held = 1; cur = idle_v(); cur.idle = 0; cur.hold = 1;
      end else if (req_valid) begin
        m_addr = req_addr; m_we = req_we; m_wdata = req_wdata; m_rdata = data_in;
        build(req_addr, req_we, req_be);
        n_acc++;
        cur = q.pop_front();
      end else cur = idle_v();
      #3;
      chk(ale == cur.ale, "R2", "ale", ale, cur.ale);
      chk(rd_n == cur.rd_n, "R3 R5 R6", "rd_n", rd_n, cur.rd_n);
      chk({wrh_n, wrl_n, data_oe} == {cur.wrh_n, cur.wrl_n, cur.doe}, "R4 R5 R6", "wrh/wrl/oe",
          {wrh_n, wrl_n, data_oe}, {cur.wrh_n, cur.wrl_n, cur.doe});
      chk(cs_n == cur.csn, "R7 R8", "cs_n", cs_n, cur.csn);
      chk(cs_oe == {cs_en[4:1], 1'b1}, "R1", "cs_oe", cs_oe, {cs_en[4:1], 1'b1});
      chk(hlda_n == !cur.hold, "R10", "hlda_n", hlda_n, !cur.hold);
      chk(req_ready == (cur.idle && hold_n), "R10", "req_ready", req_ready, cur.idle && hold_n);
      chk(rsp_valid == cur.rsp, "R11", "rsp_valid", rsp_valid, cur.rsp);
      if (cur.rsp && !m_we) chk(rsp_rdata == m_rdata, "R11", "rsp_rdata", rsp_rdata, m_rdata);
      if (!cur.idle && !cur.hold)
        chk(bus_addr == (m_addr & seg_keep()), "R9", "bus_addr", bus_addr, m_addr & seg_keep());
      if (cur.doe) chk(data_out == m_wdata, "R4", "data_out", data_out, m_wdata);
    end
  end

  task automatic start_req(input logic [22:0] a, input logic we, input logic [1:0] be,
                           input logic [15:0] wd, input logic [15:0] din);
    @(negedge clk);
    req_addr = a; req_we = we; req_be = be; req_wdata = wd; data_in = din; req_valid = 1;
  endtask

  task automatic wait_acc();
    int c = n_acc;
    while (n_acc == c) @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (!(q.size() == 0 && cur.idle)) @(negedge clk);
  endtask

  task automatic txn(input logic [22:0] a, input logic we, input logic [1:0] be,
                     input logic [15:0] wd, input logic [15:0] din);
    start_req(a, we, be, wd, din);
    wait_acc();
    wait_idle();
  endtask

  task automatic main_seq();
    // line0 addr mode tag 0; line1 read @0x10; line2 write @0x20; line3 rw @0x30; line4 addr @0x10 (overlaps line1)
    cs_mode = {2'd0, 2'd3, 2'd2, 2'd1, 2'd0};
    cs_base = {7'h10, 7'h30, 7'h20, 7'h10, 7'h00};
    cs_mask = {7'h70, 7'h70, 7'h70, 7'h70, 7'h7f};
    #2;
    chk(cs_n == 5'h1f, "R1", "cs_n in reset", cs_n, 5'h1f);
    chk(cs_oe == 5'h1f, "R1", "cs_oe in reset", cs_oe, 5'h1f);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cs_oe == 5'h1f, "R1", "cs_oe after reset", cs_oe, 5'h1f);
    // R7 R8 mode gating and priority
    txn(23'h101234, 0, 2'b11, 16'h0, 16'hA5A5);
    txn(23'h202222, 1, 2'b11, 16'h1357, 16'h0);
    txn(23'h100010, 1, 2'b01, 16'h00FF, 16'h0);
    txn(23'h200020, 0, 2'b11, 16'h0, 16'h5A5A);
    txn(23'h300030, 0, 2'b11, 16'h0, 16'h1111);
    txn(23'h300032, 1, 2'b10, 16'hBEEF, 16'h0);
    txn(23'h000100, 0, 2'b11, 16'h0, 16'h2222);
    txn(23'h500100, 0, 2'b11, 16'h0, 16'h3333);
    txn(23'h300040, 1, 2'b00, 16'hDEAD, 16'h0);   // R4 no-byte write
    cs_en = 5'b11011;                              // R8 disabled line 2
    txn(23'h200020, 1, 2'b11, 16'h4444, 16'h0);
    cs_en = 5'b11111;
    // timing sweeps R2 R3 R5 R6 R9
    for (int al = 0; al < 2; al++)
      for (int dl = 0; dl < 2; dl++)
        for (int tr = 0; tr < 2; tr++)
          for (int wi = 0; wi < 3; wi++)
            for (int sg = 0; sg < 3; sg++) begin
              cfg_ale_long = al[0]; cfg_rw_delay = dl[0]; cfg_tri_wait = tr[0];
              cfg_waits = (wi == 0) ? 4'd0 : (wi == 1) ? 4'd3 : 4'd15;
              cfg_seg = 2'(sg);
              txn({7'h30 + 7'(sg), 16'hC3A5}, 0, 2'b11, 16'h0, 16'(al * 97 + sg * 13 + wi));
              txn({7'h7A, 16'h5A3C}, 1, 2'(1 + wi), 16'h8000 | 16'(dl * 7 + tr), 16'h0);
            end
    cfg_ale_long = 0; cfg_rw_delay = 0; cfg_tri_wait = 1; cfg_waits = 4'd4; cfg_seg = 2;
    // R10 hold while idle
    @(negedge clk); hold_n = 0;
    repeat (6) @(negedge clk);
    hold_n = 1;
    repeat (3) @(negedge clk);
    // R10 hold during a cycle, with a waiting request
    start_req(23'h101000, 0, 2'b11, 16'h0, 16'h7777);
    wait_acc();
    repeat (2) @(negedge clk);
    hold_n = 0;
    req_addr = 23'h202000; req_we = 1; req_be = 2'b11; req_wdata = 16'h9999; req_valid = 1;
    repeat (20) @(negedge clk);
    hold_n = 1;
    wait_acc();
    wait_idle();
    // R10 hold and request in the same idle cycle
    @(negedge clk);
    hold_n = 0; req_addr = 23'h303000; req_we = 0; req_be = 2'b11; data_in = 16'h6666; req_valid = 1;
    repeat (4) @(negedge clk);
    hold_n = 1;
    wait_acc();
    wait_idle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule